// File: doc/BRIEF.md
# Interleaved ADC Offset Calibrator

This block sits behind a four-way time-interleaved converter and removes the DC offset differences between its channels. It receives the merged sample stream. Each word comes with the index of the channel that produced it. Channel 0 is the reference. For each of the other channels, the block keeps a running offset estimate that is learned by an LMS iteration. The error that drives each update is the corrected sample of that channel minus the most recent raw sample from the reference channel.

Every sample leaves the block one cycle after it arrives, with the integer part of its channel's estimate subtracted and the result clamped to the 12-bit signed range. The step size is a power of two chosen by a small input, so each update is an arithmetic shift. A freeze input stops learning while correction goes on. A synchronous reset clears the learned state.

Top module: `ilv_offset_cal`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. `out_sample` is registered and changes only on such cycles.
- R2: Channel 0 is the reference. Its samples come out unchanged and its estimate field always reads zero.
- R3: Each estimate is a 20-bit signed value with 8 fractional bits. The estimate of channel k sits at bits [20k+19:20k] of `offset_est`. The corrected sample is the raw sample minus floor(estimate / 256), computed with the estimate held before that sample's update.
- R4: The reference register holds the latest raw channel-0 sample and is zero after reset. For a valid sample on channel k≠0 with freeze low, the estimate becomes estimate + ((e·256) >>> m), where e = corrected sample − reference register and >>> is an arithmetic right shift. Nothing else changes an estimate.
- R5: The shift m is the `mu` input clamped to the range 4..12. Values below 4 act as 4 and values above 12 act as 12.
- R6: An estimate update saturates at −524288 and +524287 and does not wrap.
- R7: The corrected sample saturates at −2048 and +2047.
- R8: While `freeze` is high, all estimates hold, and samples are still corrected with the held estimates.
- R9: A cycle with `rst` high clears every estimate, the reference register and `out_valid` by the next cycle.
- R10: With constant per-channel offsets and m = 4, the integer part of each estimate settles within 1 LSB of that channel's offset relative to channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of estimates, reference and output valid |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 12 | Raw signed sample |
| in_chan | input | 2 | Index of the channel that produced the sample |
| mu | input | 4 | Step-size exponent, clamped to 4..12 |
| freeze | input | 1 | Holds all estimates while high |
| out_valid | output | 1 | Corrected sample strobe, one cycle after in_valid |
| out_sample | output | 12 | Corrected signed sample |
| offset_est | output | 80 | Four 20-bit estimates, channel k at bits [20k+19:20k] |

## Verification
The bench checks the first update after reset against exact step values with `mu` set both below and above its legal range. A design that skipped the clamp would move the estimate by a step 16 times too large, or by a smaller one. It drives one channel against an opposite-rail reference until the estimate is pinned at its limit. A wrapping accumulator would flip sign there, and an unclamped subtractor would wrap the output from one rail to the other. Freeze and mid-run reset are checked at the estimate port: learning that leaks through freeze, or a reference register that survives reset, shows up as a mismatch in the following outputs.

// File: rtl/ocal_pkg.sv
package ocal_pkg;
  // Clamp an integer into [lo, hi]; used for step exponent and saturation.
  function automatic int clamp_int(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/ocal_corrector.sv
module ocal_corrector
  import ocal_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int EST_W  = 20,
  parameter int FRAC_W = 8
) (
  input  logic signed [DATA_W-1:0] raw,
  input  logic signed [EST_W-1:0]  est,
  output logic signed [DATA_W-1:0] corr
);
  localparam int OUT_MIN = -(2 ** (DATA_W - 1));
  localparam int OUT_MAX = (2 ** (DATA_W - 1)) - 1;

  logic signed [EST_W-1:0] est_int;
  int diff;

  always_comb begin
    est_int = est >>> FRAC_W;           // floor of the fixed-point estimate
    diff    = int'(raw) - int'(est_int);
    corr    = DATA_W'(clamp_int(diff, OUT_MIN, OUT_MAX));
  end
endmodule

// File: rtl/ocal_lms_step.sv
module ocal_lms_step
  import ocal_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int EST_W  = 20,
  parameter int FRAC_W = 8,
  parameter int MU_W   = 4,
  parameter int MU_MIN = 4,
  parameter int MU_MAX = 12
) (
  input  logic signed [EST_W-1:0]  est,
  input  logic signed [DATA_W-1:0] corr,
  input  logic signed [DATA_W-1:0] ref_smp,
  input  logic        [MU_W-1:0]   mu,
  output logic signed [EST_W-1:0]  est_nxt
);
  localparam int EST_MIN = -(2 ** (EST_W - 1));
  localparam int EST_MAX = (2 ** (EST_W - 1)) - 1;

  int err, step, shift, sum;

  always_comb begin
    shift   = clamp_int(int'(mu), MU_MIN, MU_MAX);
    err     = int'(corr) - int'(ref_smp);
    step    = (err <<< FRAC_W) >>> shift;
    sum     = int'(est) + step;
    est_nxt = EST_W'(clamp_int(sum, EST_MIN, EST_MAX));
  end
endmodule

// File: rtl/ocal_est_bank.sv
module ocal_est_bank #(
  parameter int NUM_CH = 4,
  parameter int EST_W  = 20,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [CH_W-1:0]          wr_idx,
  input  logic signed [EST_W-1:0]  wr_data,
  input  logic [CH_W-1:0]          rd_idx,
  output logic signed [EST_W-1:0]  rd_data,
  output logic [NUM_CH*EST_W-1:0]  est_flat
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    if (g == 0) begin : g_ref
      assign est_flat[0 +: EST_W] = '0;     // reference channel never learns
    end else begin : g_lrn
      logic signed [EST_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= '0;
        else if (wr_en && (int'(wr_idx) == g))
          q <= wr_data;
      end
      assign est_flat[g*EST_W +: EST_W] = q;
    end
  end

  assign rd_data = est_flat[int'(rd_idx)*EST_W +: EST_W];
endmodule

// File: rtl/ilv_offset_cal.sv
module ilv_offset_cal #(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 4,
  parameter int FRAC_W = 8,
  parameter int MU_W   = 4,
  parameter int MU_MIN = 4,
  parameter int MU_MAX = 12,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int EST_W = DATA_W + FRAC_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic signed [DATA_W-1:0]   in_sample,
  input  logic [CH_W-1:0]            in_chan,
  input  logic [MU_W-1:0]            mu,
  input  logic                       freeze,
  output logic                       out_valid,
  output logic signed [DATA_W-1:0]   out_sample,
  output logic [NUM_CH*EST_W-1:0]    offset_est
);
  logic signed [DATA_W-1:0] ref_q;
  logic signed [DATA_W-1:0] corr;
  logic signed [EST_W-1:0]  est_cur, est_nxt;
  logic                     upd_en;

  assign upd_en = in_valid && !freeze && (in_chan != '0);

  ocal_est_bank #(.NUM_CH(NUM_CH), .EST_W(EST_W), .CH_W(CH_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(upd_en), .wr_idx(in_chan), .wr_data(est_nxt),
    .rd_idx(in_chan), .rd_data(est_cur), .est_flat(offset_est)
  );

  ocal_corrector #(.DATA_W(DATA_W), .EST_W(EST_W), .FRAC_W(FRAC_W)) u_corr (
    .raw(in_sample), .est(est_cur), .corr(corr)
  );

  ocal_lms_step #(.DATA_W(DATA_W), .EST_W(EST_W), .FRAC_W(FRAC_W), .MU_W(MU_W),
                  .MU_MIN(MU_MIN), .MU_MAX(MU_MAX)) u_step (
    .est(est_cur), .corr(corr), .ref_smp(ref_q), .mu(mu), .est_nxt(est_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q      <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sample <= corr;
        if (in_chan == '0) ref_q <= in_sample;
      end
    end
  end

  // R1: output strobe tracks the input strobe one cycle later
  p_valid_lag_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R2: reference samples pass through untouched
  p_ref_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_chan == '0) |=> (out_sample == $past(in_sample)));
  // R8: frozen estimates do not move
  p_freeze_hold_r8: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(offset_est));
  // R4: estimates move only on a valid sample
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(offset_est));
  // R9: reset clears learned state and the output strobe
  p_clear_r9: assert property (@(posedge clk)
    rst |=> (offset_est == '0 && !out_valid));
endmodule

// File: tb/ilv_offset_cal_test.sv
module ilv_offset_cal_test;
  localparam int EW = 20;
  logic clk = 0, rst = 1, in_valid = 0, freeze = 0;
  logic signed [11:0] in_sample = '0;
  logic [1:0] in_chan = '0;
  logic [3:0] mu = 4'd4;
  logic out_valid;
  logic signed [11:0] out_sample;
  logic [79:0] offset_est;

  int errors = 0, checks = 0;
  int exp_q[$];
  int m_est[4];
  int m_ref;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  ilv_offset_cal uut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .in_chan(in_chan), .mu(mu), .freeze(freeze), .out_valid(out_valid),
    .out_sample(out_sample), .offset_est(offset_est));

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic int est_of(int k);
    logic signed [19:0] s;
    s = offset_est[k*EW +: EW];
    return int'(s);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: presents one sample and pushes its expected output (R3/R4/R5/R6/R7/R8 model)
  task automatic send(int ch, int x);
    int y, e, sh;
    @(negedge clk);
    in_valid = 1; in_chan = 2'(ch); in_sample = 12'(x);
    y = clampi(x - (m_est[ch] >>> 8), -2048, 2047);
    exp_q.push_back(y);
    if (ch == 0) m_ref = x;
    else if (!freeze) begin
      sh = clampi(int'(mu), 4, 12);
      e = y - m_ref;
      m_est[ch] = clampi(m_est[ch] + ((e <<< 8) >>> sh), -524288, 524287);
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 0;
    repeat (n) @(negedge clk);
    check("R1 idle valid", int'(out_valid), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    foreach (m_est[k]) m_est[k] = 0;
    m_ref = 0;
    check("R9 valid after reset", int'(out_valid), 0);
    for (int k = 0; k < 4; k++) check("R9 estimate cleared", est_of(k), 0);
  endtask

  task automatic check_est(string req);
    for (int k = 0; k < 4; k++) check(req, est_of(k), m_est[k]);
  endtask

  // Monitor: compares each produced sample with the queued expectation
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) check("R1 unexpected valid", 1, 0);
      else check("R3 corrected sample", int'(out_sample), exp_q.pop_front());
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R5: exponent below range acts as 4
    mu = 4'd0;
    send(0, 0); send(1, 100);
    idle(2);
    check("R5 low clamp step", est_of(1), 1600);
    // R5: exponent above range acts as 12
    mu = 4'd15;
    send(2, 100);
    idle(2);
    check("R5 high clamp step", est_of(2), 6);
    check("R2 reference estimate", est_of(0), 0);

    // R10: constant offsets converge
    do_reset();
    mu = 4'd4;
    for (int r = 0; r < 150; r++) begin
      send(0, 100); send(1, 130); send(2, 55); send(3, 107);
    end
    idle(2);
    check_est("R4 estimates after run");
    check("R10 ch1 converged", int'(((est_of(1) >>> 8) - 30) inside {[-1:1]}), 1);
    check("R10 ch2 converged", int'(((est_of(2) >>> 8) + 45) inside {[-1:1]}), 1);
    check("R10 ch3 converged", int'(((est_of(3) >>> 8) - 7) inside {[-1:1]}), 1);

    // R8: freeze holds estimates, correction continues
    freeze = 1;
    for (int r = 0; r < 5; r++) begin
      send(0, -300); send(1, 400); send(2, -7); send(3, 900);
    end
    idle(2);
    check_est("R8 frozen estimates");
    freeze = 0;

    // R6/R7: drive to the rails
    do_reset();
    mu = 4'd4;
    for (int r = 0; r < 20; r++) begin
      send(0, -2048); send(1, 2047); send(0, 2047); send(2, -2048);
    end
    idle(2);
    check("R6 upper estimate rail", est_of(1), 524287);
    check("R6 lower estimate rail", est_of(2), -524288);
    freeze = 1;
    send(1, -2048);   // -2048 - 2047 -> clamps to -2048 (R7)
    send(2, 2047);    // 2047 + 2048 -> clamps to 2047 (R7)
    send(3, -5);
    idle(2);
    freeze = 0;

    // R9: mid-run reset clears reference register too
    send(0, 500); send(1, 20);
    idle(2);
    do_reset();
    mu = 4'd6;
    send(3, 40); send(1, -12); send(0, 8); send(3, 40);
    idle(2);
    check_est("R9 learning from cleared reference");
    check("R1 queue drained", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule